// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block models the command side of a small parallel NOR flash. A host drives chip-enable, write-enable and output-enable strobes, all active low and sampled on a system clock, together with an address and a data byte. Falling edges of write-enable carry command cycles. Falling edges of output-enable carry reads. The interpreter tracks the multi-cycle unlock sequences and starts program or sector-erase operations on a small on-chip array. While an operation runs, it reports progress through a ready/busy pin and through status bits on the data output.

An erase first drives every non-zero word of the chosen sector to zero, then sets the whole sector to all ones. The erase can be paused so that other sectors can be read and written, then resumed. An unlock-bypass mode shortens a program to two write cycles. A per-sector lock vector blocks program and erase on selected sectors, and a write-protect pin blocks sector 0 whatever its lock bit says. Operation times come from two cycle-count parameters: PROG_CYC per programmed word and ERS_CYC for the final erase step.

Command words are decoded from data bits 7:0 and address bits 10:0. The array word index is the low address bits. With the defaults (4 sectors of 8 bytes), address bits 4:3 select the sector.

Top module: `nfl_flash_top`

## Requirements
- R1: While rst_n is low, any operation is abandoned. After release, ry_by is 1, the sequence decoder is back in read mode, and every array byte reads 8'hFF.
- R2: The write sequence AA@555, 55@2AA, A0@555, D@A programs byte A. When done, the byte holds its old value AND D, so a program can only clear bits.
- R3: ry_by goes to 0 on the clock edge that takes the final program write cycle. It stays 0 for exactly PROG_CYC cycles.
- R4: While a program is busy, a read returns status instead of array data. Bit 7 is the complement of bit 7 of the data being programmed, bits 5:0 are 0, and bit 6 inverts on every read strobe.
- R5: The sequence AA@555, 55@2AA, 80@555, AA@555, 55@2AA, 30@(any address in the sector) erases that sector. Each non-zero byte is zeroed in PROG_CYC cycles and each zero byte costs 1 cycle. ERS_CYC further cycles follow, and then every byte of the sector reads FF. While the erase is busy, status bit 7 reads 0.
- R6: AA@555, 55@2AA, 20@555 enters bypass mode. There, A0 followed by D@A programs. 90 followed by 00 leaves bypass, after which a lone A0, D@A pair has no effect.
- R7: A write that does not fit the expected sequence returns the decoder to read mode, so the sequence must restart. In bypass mode, an unexpected write leaves the decoder in bypass.
- R8: Writing B0 during an erase suspends it, and ry_by is 1 on the next cycle. While suspended, reads return array data, and programs to other sectors run and return to suspension. A program to the sector being erased is ignored. Writing 30 in read mode resumes the erase, which then completes.
- R9: A program or erase aimed at a sector whose sec_lock bit is 1 is ignored. ry_by stays 1 and the array is unchanged.
- R10: While wp_n is 0, sector 0 is protected even when sec_lock[0] is 0.
- R11: Write cycles during a busy program, and write cycles other than B0 during a busy erase, are ignored.
- R12: dout is 0 whenever ce_n or oe_n is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus strobes |
| rst_n | input | 1 | Asynchronous active-low reset; aborts any operation |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low; its falling edge is a write cycle |
| oe_n | input | 1 | Output enable, active low; its falling edge is a read strobe |
| addr | input | ADDR_W | Byte address and command address |
| din | input | DW | Write data or command code |
| wp_n | input | 1 | Write protect for sector 0, active low |
| sec_lock | input | NSEC | Per-sector protection bits |
| dout | output | DW | Array data, or status while busy |
| ry_by | output | 1 | 1 when ready, 0 while a program or erase runs |

## Verification
On every cycle, the assertions check the following:
- an accepted program makes the block busy on the next cycle;
- a finished program leaves the old byte ANDed with the new data;
- a program to a locked sector leaves the block ready;
- status bit 7 reads 0 throughout an erase;
- a suspended erase reports ready;
- write cycles during a busy program do not move the decoder.

Only the bench scenarios can show the following:
- the exact busy durations of a program and of a preprogram-plus-erase;
- the status bit 6 inversion across two reads;
- bypass entry and exit;
- recovery from a wrong cycle;
- suspend, a program to another sector, and resume;
- write-protect overriding the lock bit;
- reset abandoning a program part way through.

// File: rtl/nfl_pkg.sv
package nfl_pkg;
  typedef enum logic [3:0] {
    D_READ, D_UL1, D_UL2, D_PGM, D_ER1, D_ER2, D_ER3, D_BYP, D_BPGM, D_BEXIT
  } dec_st_t;

  typedef enum logic [2:0] {X_IDLE, X_PROG, X_PRE, X_ERS, X_SUSP} ex_st_t;

  localparam logic [10:0] A_KEY1 = 11'h555;
  localparam logic [10:0] A_KEY2 = 11'h2AA;
  localparam logic [7:0]  C_KEY1 = 8'hAA;
  localparam logic [7:0]  C_KEY2 = 8'h55;
  localparam logic [7:0]  C_PGM  = 8'hA0;
  localparam logic [7:0]  C_ERS  = 8'h80;
  localparam logic [7:0]  C_SEC  = 8'h30;
  localparam logic [7:0]  C_BYP  = 8'h20;
  localparam logic [7:0]  C_BX1  = 8'h90;
  localparam logic [7:0]  C_BX2  = 8'h00;
  localparam logic [7:0]  C_SUS  = 8'hB0;
  localparam logic [7:0]  C_RES  = 8'h30;

  // One command cycle match: address and code both equal.
  function automatic logic cyc_hit(input logic [10:0] a, input logic [7:0] d,
                                   input logic [10:0] ea, input logic [7:0] ed);
    return (a == ea) && (d == ed);
  endfunction

  // A program can only clear bits.
  function automatic logic [7:0] prog_merge(input logic [7:0] old_w, input logic [7:0] new_w);
    return old_w & new_w;
  endfunction
endpackage

// File: rtl/nfl_decode.sv
module nfl_decode
  import nfl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_stb,
  input  logic [10:0] cmd_a,
  input  logic [7:0]  cmd_d,
  input  logic        accept,
  input  logic        erasing,
  input  logic        suspended,
  output logic        go_prog,
  output logic        go_erase,
  output logic        do_susp,
  output logic        do_res,
  output dec_st_t     st
);
  dec_st_t nxt;

  always_comb begin
    nxt      = st;
    go_prog  = 1'b0;
    go_erase = 1'b0;
    do_susp  = 1'b0;
    do_res   = 1'b0;
    if (wr_stb) begin
      if (erasing) begin
        do_susp = (cmd_d == C_SUS);
      end else if (accept) begin
        case (st)
          D_READ: begin
            if (suspended && cmd_d == C_RES) do_res = 1'b1;
            else if (cyc_hit(cmd_a, cmd_d, A_KEY1, C_KEY1)) nxt = D_UL1;
          end
          D_UL1: nxt = cyc_hit(cmd_a, cmd_d, A_KEY2, C_KEY2) ? D_UL2 : D_READ;
          D_UL2: begin
            if (cyc_hit(cmd_a, cmd_d, A_KEY1, C_PGM))      nxt = D_PGM;
            else if (cyc_hit(cmd_a, cmd_d, A_KEY1, C_ERS)) nxt = D_ER1;
            else if (cyc_hit(cmd_a, cmd_d, A_KEY1, C_BYP)) nxt = D_BYP;
            else                                           nxt = D_READ;
          end
          D_PGM: begin
            go_prog = 1'b1;
            nxt     = D_READ;
          end
          D_ER1: nxt = cyc_hit(cmd_a, cmd_d, A_KEY1, C_KEY1) ? D_ER2 : D_READ;
          D_ER2: nxt = cyc_hit(cmd_a, cmd_d, A_KEY2, C_KEY2) ? D_ER3 : D_READ;
          D_ER3: begin
            go_erase = (cmd_d == C_SEC);
            nxt      = D_READ;
          end
          D_BYP: begin
            if (cmd_d == C_PGM)      nxt = D_BPGM;
            else if (cmd_d == C_BX1) nxt = D_BEXIT;
          end
          D_BPGM: begin
            go_prog = 1'b1;
            nxt     = D_BYP;
          end
          D_BEXIT: nxt = (cmd_d == C_BX2) ? D_READ : D_BYP;
          default: nxt = D_READ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= D_READ;
    else        st <= nxt;
endmodule

// File: rtl/nfl_engine.sv
module nfl_engine
  import nfl_pkg::*;
#(
  parameter int DW       = 8,
  parameter int NSEC     = 4,
  parameter int WPS      = 8,
  parameter int PROG_CYC = 16,
  parameter int ERS_CYC  = 40,
  localparam int SEC_W   = $clog2(NSEC),
  localparam int WPS_W   = $clog2(WPS),
  localparam int IDX_W   = SEC_W + WPS_W,
  localparam int NWORDS  = NSEC * WPS,
  localparam int MAXC    = (PROG_CYC > ERS_CYC) ? PROG_CYC : ERS_CYC,
  localparam int CW      = $clog2(MAXC + 1)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_prog,
  input  logic             go_erase,
  input  logic             do_susp,
  input  logic             do_res,
  input  logic [IDX_W-1:0] widx,
  input  logic [DW-1:0]    wdata,
  input  logic [NSEC-1:0]  lock_eff,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_word,
  output logic [DW-1:0]    chk_word,
  output logic [DW-1:0]    pdat,
  output logic             prog_acc,
  output logic             prog_done,
  output ex_st_t           st
);
  logic [DW-1:0]    mem [NWORDS];
  ex_st_t           held;
  logic             from_susp;
  logic [SEC_W-1:0] esec;
  logic [WPS_W-1:0] wptr;
  logic [CW-1:0]    ecnt, pcnt;
  logic [IDX_W-1:0] pidx;
  logic [SEC_W-1:0] wsec;
  logic [IDX_W-1:0] cur;
  logic             ers_acc, cur_zero;

  assign wsec     = widx[IDX_W-1:WPS_W];
  assign cur      = {esec, wptr};
  assign cur_zero = (mem[cur] == '0);
  assign prog_acc = go_prog && !lock_eff[wsec] &&
                    (st == X_IDLE || (st == X_SUSP && wsec != esec));
  assign ers_acc   = go_erase && !lock_eff[wsec] && (st == X_IDLE);
  assign prog_done = (st == X_PROG) && (pcnt == '0);
  assign rd_word   = mem[rd_idx];
  assign chk_word  = mem[pidx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= X_IDLE;
      held      <= X_PRE;
      from_susp <= 1'b0;
      esec      <= '0;
      wptr      <= '0;
      ecnt      <= '0;
      pcnt      <= '0;
      pidx      <= '0;
      pdat      <= '0;
      for (int i = 0; i < NWORDS; i++) mem[i] <= '1;
    end else begin
      case (st)
        X_IDLE, X_SUSP: begin
          if (st == X_SUSP && do_res) begin
            st <= held;
          end else if (prog_acc) begin
            st        <= X_PROG;
            from_susp <= (st == X_SUSP);
            pidx      <= widx;
            pdat      <= wdata;
            pcnt      <= CW'(PROG_CYC - 1);
          end else if (ers_acc) begin
            st   <= X_PRE;
            esec <= wsec;
            wptr <= '0;
            ecnt <= '0;
          end
        end
        X_PROG: begin
          if (pcnt == '0) begin
            mem[pidx] <= prog_merge(mem[pidx], pdat);
            st        <= from_susp ? X_SUSP : X_IDLE;
          end else begin
            pcnt <= pcnt - 1'b1;
          end
        end
        X_PRE: begin
          if (do_susp) begin
            held <= X_PRE;
            st   <= X_SUSP;
          end else if (cur_zero || ecnt == CW'(PROG_CYC - 1)) begin
            mem[cur] <= '0;
            if (wptr == WPS_W'(WPS - 1)) begin
              st   <= X_ERS;
              ecnt <= CW'(ERS_CYC - 1);
            end else begin
              wptr <= wptr + 1'b1;
              ecnt <= '0;
            end
          end else begin
            ecnt <= ecnt + 1'b1;
          end
        end
        X_ERS: begin
          if (do_susp) begin
            held <= X_ERS;
            st   <= X_SUSP;
          end else if (ecnt == '0) begin
            for (int w = 0; w < WPS; w++) mem[{esec, WPS_W'(w)}] <= '1;
            st <= X_IDLE;
          end else begin
            ecnt <= ecnt - 1'b1;
          end
        end
        default: st <= X_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nfl_status.sv
module nfl_status #(
  parameter int DW = 8
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_stb,
  input  logic          busy,
  input  logic          erase_busy,
  input  logic          prog_b7,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic [DW-1:0] arr_word,
  output logic [DW-1:0] dout
);
  logic          tog;
  logic [DW-1:0] stat;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              tog <= 1'b0;
    else if (rd_stb && busy) tog <= ~tog;

  always_comb begin
    stat    = '0;
    stat[7] = erase_busy ? 1'b0 : ~prog_b7;
    stat[6] = tog;
    if (ce_n || oe_n) dout = '0;
    else if (busy)    dout = stat;
    else              dout = arr_word;
  end
endmodule

// File: rtl/nfl_flash_top.sv
module nfl_flash_top
  import nfl_pkg::*;
#(
  parameter int DW       = 8,
  parameter int ADDR_W   = 11,
  parameter int NSEC     = 4,
  parameter int WPS      = 8,
  parameter int PROG_CYC = 16,
  parameter int ERS_CYC  = 40
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     din,
  input  logic              wp_n,
  input  logic [NSEC-1:0]   sec_lock,
  output logic [DW-1:0]     dout,
  output logic              ry_by
);
  localparam int SEC_W = $clog2(NSEC);
  localparam int WPS_W = $clog2(WPS);
  localparam int IDX_W = SEC_W + WPS_W;

  function automatic logic [NSEC-1:0] eff_lock(input logic [NSEC-1:0] lk, input logic wp);
    logic [NSEC-1:0] r;
    r = lk;
    if (!wp) r[0] = 1'b1;
    return r;
  endfunction

  logic            we_q, oe_q;
  logic            wr_stb, rd_stb;
  logic            go_prog, go_erase, do_susp, do_res;
  logic            prog_acc, prog_done, prog_blocked;
  logic            busy, erase_busy, suspended;
  logic [NSEC-1:0] lock_eff;
  logic [DW-1:0]   rd_word, chk_word, pdat;
  dec_st_t         dec_st;
  ex_st_t          ex_st;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      we_q <= 1'b1;
      oe_q <= 1'b1;
    end else begin
      we_q <= we_n;
      oe_q <= oe_n;
    end

  assign wr_stb       = !ce_n && !we_n && we_q;
  assign rd_stb       = !ce_n && !oe_n && oe_q;
  assign lock_eff     = eff_lock(sec_lock, wp_n);
  assign prog_blocked = go_prog && lock_eff[addr[IDX_W-1:WPS_W]];
  assign erase_busy   = (ex_st == X_PRE) || (ex_st == X_ERS);
  assign busy         = erase_busy || (ex_st == X_PROG);
  assign suspended    = (ex_st == X_SUSP);
  assign ry_by        = !busy;

  nfl_decode u_dec (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb),
    .cmd_a(addr[10:0]), .cmd_d(din[7:0]),
    .accept(!busy), .erasing(erase_busy), .suspended(suspended),
    .go_prog(go_prog), .go_erase(go_erase), .do_susp(do_susp), .do_res(do_res),
    .st(dec_st)
  );

  nfl_engine #(.DW(DW), .NSEC(NSEC), .WPS(WPS), .PROG_CYC(PROG_CYC), .ERS_CYC(ERS_CYC)) u_eng (
    .clk(clk), .rst_n(rst_n), .go_prog(go_prog), .go_erase(go_erase),
    .do_susp(do_susp), .do_res(do_res), .widx(addr[IDX_W-1:0]), .wdata(din),
    .lock_eff(lock_eff), .rd_idx(addr[IDX_W-1:0]), .rd_word(rd_word),
    .chk_word(chk_word), .pdat(pdat), .prog_acc(prog_acc), .prog_done(prog_done),
    .st(ex_st)
  );

  nfl_status #(.DW(DW)) u_stat (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .busy(busy), .erase_busy(erase_busy),
    .prog_b7(pdat[7]), .ce_n(ce_n), .oe_n(oe_n), .arr_word(rd_word), .dout(dout)
  );
endmodule

// File: rtl/nfl_flash_chk.sv
module nfl_flash_chk
  import nfl_pkg::*;
#(
  parameter int DW = 8
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic [DW-1:0] dout,
  input  logic          ry_by,
  input  logic          wr_stb,
  input  logic          busy,
  input  logic          erase_busy,
  input  logic          suspended,
  input  logic          prog_acc,
  input  logic          prog_done,
  input  logic          prog_blocked,
  input  logic [DW-1:0] chk_word,
  input  logic [DW-1:0] pdat,
  input  dec_st_t       dec_st
);
  a_r3_prog_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    prog_acc |=> !ry_by);

  a_r2_prog_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> chk_word == ($past(chk_word) & $past(pdat)));

  a_r9_locked_stays_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_blocked && ry_by) |=> ry_by);

  a_r5_erase_dq7_low: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_busy && !ce_n && !oe_n) |-> (dout[7] == 1'b0));

  a_r8_suspend_ready: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> ry_by);

  a_r11_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !erase_busy && wr_stb) |=> $stable(dec_st));
endmodule

bind nfl_flash_top nfl_flash_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .dout(dout), .ry_by(ry_by),
  .wr_stb(wr_stb), .busy(busy), .erase_busy(erase_busy), .suspended(suspended),
  .prog_acc(prog_acc), .prog_done(prog_done), .prog_blocked(prog_blocked),
  .chk_word(chk_word), .pdat(pdat), .dec_st(dec_st)
);

// File: tb/nfl_flash_top_test.sv
module nfl_flash_top_test;
  localparam int PC = 16;
  localparam int EC = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, wp_n = 1'b1;
  logic [10:0] addr = '0;
  logic [7:0]  din = '0;
  logic [3:0]  sec_lock = '0;
  logic [7:0]  dout;
  logic        ry_by;
  int nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  nfl_flash_top #(.PROG_CYC(PC), .ERS_CYC(EC)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
    .din(din), .wp_n(wp_n), .sec_lock(sec_lock), .dout(dout), .ry_by(ry_by)
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // Write cycle: we_n low over one edge, high over the next; returns at a negedge.
  task automatic wr(input logic [10:0] a, input logic [7:0] d);
    ce_n = 1'b0; addr = a; din = d; we_n = 1'b0;
    @(posedge clk); @(negedge clk);
    we_n = 1'b1;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rd(input logic [10:0] a, output logic [7:0] v);
    ce_n = 1'b0; addr = a; oe_n = 1'b0;
    @(posedge clk); @(negedge clk);
    v = dout; oe_n = 1'b1;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wait_ready();
    for (int k = 0; k < 2000 && !ry_by; k++) @(negedge clk);
  endtask

  // Counts negedges with ry_by low, starting just after a write task returns.
  task automatic busy_len(output int n);
    n = 0;
    while (!ry_by && n < 2000) begin n++; @(negedge clk); end
  endtask

  task automatic prog4(input logic [10:0] a, input logic [7:0] d);
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'hA0); wr(a, d);
  endtask

  task automatic erase6(input logic [10:0] sa);
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h80);
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(sa, 8'h30);
  endtask

  // Vector: op(2) addr(11) data(8) expect(8) req(4); op 0 write, 1 read-check, 2 wait ready.
  localparam int NV = 32;
  localparam logic [32:0] TBL [NV] = '{
    // R2 four-cycle program, then a second program ANDs in
    {2'd0, 11'h555, 8'hAA, 8'h00, 4'd2}, {2'd0, 11'h2AA, 8'h55, 8'h00, 4'd2},
    {2'd0, 11'h555, 8'hA0, 8'h00, 4'd2}, {2'd0, 11'h003, 8'h5A, 8'h00, 4'd2},
    {2'd2, 11'h000, 8'h00, 8'h00, 4'd2}, {2'd1, 11'h003, 8'h00, 8'h5A, 4'd2},
    {2'd0, 11'h555, 8'hAA, 8'h00, 4'd2}, {2'd0, 11'h2AA, 8'h55, 8'h00, 4'd2},
    {2'd0, 11'h555, 8'hA0, 8'h00, 4'd2}, {2'd0, 11'h003, 8'h0F, 8'h00, 4'd2},
    {2'd2, 11'h000, 8'h00, 8'h00, 4'd2}, {2'd1, 11'h003, 8'h00, 8'h0A, 4'd2},
    // R6 bypass entry and two-cycle program
    {2'd0, 11'h555, 8'hAA, 8'h00, 4'd6}, {2'd0, 11'h2AA, 8'h55, 8'h00, 4'd6},
    {2'd0, 11'h555, 8'h20, 8'h00, 4'd6}, {2'd0, 11'h000, 8'hA0, 8'h00, 4'd6},
    {2'd0, 11'h009, 8'h33, 8'h00, 4'd6}, {2'd2, 11'h000, 8'h00, 8'h00, 4'd6},
    {2'd1, 11'h009, 8'h00, 8'h33, 4'd6},
    // R7 stray write inside bypass keeps bypass
    {2'd0, 11'h000, 8'h77, 8'h00, 4'd7}, {2'd0, 11'h000, 8'hA0, 8'h00, 4'd7},
    {2'd0, 11'h004, 8'h3C, 8'h00, 4'd7}, {2'd2, 11'h000, 8'h00, 8'h00, 4'd7},
    {2'd1, 11'h004, 8'h00, 8'h3C, 4'd7},
    // R6 exit then a two-cycle program does nothing
    {2'd0, 11'h000, 8'h90, 8'h00, 4'd6}, {2'd0, 11'h000, 8'h00, 8'h00, 4'd6},
    {2'd0, 11'h000, 8'hA0, 8'h00, 4'd6}, {2'd0, 11'h00A, 8'h00, 8'h00, 4'd6},
    // R7 wrong second unlock cycle aborts the sequence
    {2'd0, 11'h555, 8'hAA, 8'h00, 4'd7}, {2'd0, 11'h2AA, 8'h56, 8'h00, 4'd7},
    {2'd0, 11'h555, 8'hA0, 8'h00, 4'd7}, {2'd0, 11'h00B, 8'h12, 8'h00, 4'd7}
  };

  initial begin : watchdog
    #2_000_000;
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin : main
    logic [7:0] v, v2;
    int n, exp_n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R12 output quiet with oe_n high
    check("R1 ready", ry_by, 1'b1);
    rd(11'h000, v); check("R1 erased", v, 8'hFF);
    rd(11'h01F, v); check("R1 erased", v, 8'hFF);
    ce_n = 1'b0; oe_n = 1'b1; #1; check("R12 quiet", dout, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [32:0] e;
      e = TBL[i];
      case (e[32:31])
        2'd0: wr(e[30:20], e[19:12]);
        2'd1: begin rd(e[30:20], v); check($sformatf("R%0d table", e[3:0]), v, e[11:4]); end
        default: wait_ready();
      endcase
    end
    wait_ready();
    rd(11'h00A, v); check("R6 exit", v, 8'hFF);
    rd(11'h00B, v); check("R7 abort", v, 8'hFF);

    // R3 program duration (one busy cycle passes inside the write task)
    prog4(11'h00C, 8'h00); busy_len(n);
    check("R3 busy len", n, PC - 1);
    rd(11'h00C, v); check("R3 data", v, 8'h00);

    // R4 status while programming
    prog4(11'h006, 8'h7E);
    rd(11'h006, v); rd(11'h006, v2);
    check("R4 dq7", v[7], 1'b1);
    check("R4 low bits", v[5:0], 6'h00);
    check("R4 toggle", v[6] ^ v2[6], 1'b1);
    wait_ready();
    rd(11'h006, v); check("R4 done data", v, 8'h7E);

    // R11 writes during a busy program are ignored
    prog4(11'h007, 8'hF0);
    prog4(11'h007, 8'h00);
    wait_ready();
    wr(11'h007, 8'h00);
    rd(11'h007, v); check("R11 ignored", v, 8'hF0);

    // R5 erase of sector 1 with duration from the visible contents
    exp_n = EC;
    for (int w = 8; w < 16; w++) begin
      rd(11'(w), v);
      exp_n += (v != 8'h00) ? PC : 1;
    end
    erase6(11'h008); busy_len(n);
    check("R5 erase len", n, exp_n - 1);
    for (int w = 8; w < 16; w++) begin
      rd(11'(w), v); check("R5 blank", v, 8'hFF);
    end

    // R9 locked sector 2: program and erase ignored
    prog4(11'h012, 8'h11); wait_ready();
    sec_lock = 4'b0100;
    prog4(11'h011, 8'h00);
    check("R9 no busy", ry_by, 1'b1);
    rd(11'h011, v); check("R9 prog", v, 8'hFF);
    erase6(11'h010);
    check("R9 no busy", ry_by, 1'b1);
    rd(11'h012, v); check("R9 erase", v, 8'h11);
    sec_lock = 4'b0000;

    // R10 write-protect pin guards sector 0
    wp_n = 1'b0;
    prog4(11'h001, 8'h00);
    check("R10 no busy", ry_by, 1'b1);
    rd(11'h001, v); check("R10 held", v, 8'hFF);
    wp_n = 1'b1;
    prog4(11'h001, 8'hC3); wait_ready();
    rd(11'h001, v); check("R10 released", v, 8'hC3);

    // R8 suspend and resume an erase of sector 3
    erase6(11'h018);
    rd(11'h018, v);
    check("R5 dq7 erase", v[7], 1'b0);
    check("R5 low bits", v[5:0], 6'h00);
    repeat (18) @(negedge clk);
    wr(11'h000, 8'hB0);
    check("R8 ready", ry_by, 1'b1);
    rd(11'h018, v); check("R8 preprogrammed", v, 8'h00);
    prog4(11'h002, 8'hA5); wait_ready();
    rd(11'h002, v); check("R8 other sector", v, 8'hA5);
    prog4(11'h01B, 8'h00);
    check("R8 same sector ready", ry_by, 1'b1);
    rd(11'h01B, v); check("R8 same sector", v, 8'hFF);
    wr(11'h000, 8'h30);
    check("R8 resumed busy", ry_by, 1'b0);
    wait_ready();
    for (int w = 24; w < 32; w++) begin
      rd(11'(w), v); check("R8 blank", v, 8'hFF);
    end

    // R1 reset aborts a program in progress
    prog4(11'h00D, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 abort ready", ry_by, 1'b1);
    rd(11'h00D, v); check("R1 abort data", v, 8'hFF);
    rd(11'h003, v); check("R1 array reset", v, 8'hFF);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule